// File: doc/BRIEF.md
# Time-of-Day Counter with Drift Correction

This block keeps a free-running wall-clock time for precision timing logic. Every clock cycle it adds a programmable step, given as whole nanoseconds plus a 16-bit fraction of a nanosecond, to a nanosecond accumulator. When the nanoseconds reach one billion, the count wraps and a 48-bit seconds counter advances. The current time is presented at all times in two forms. The first is a 96-bit seconds/nanoseconds/fraction stamp. The second is a 64-bit stamp built from a 48-bit running count of nanoseconds and the same 16-bit fraction.

A write-only configuration port sets the time, the per-cycle period, and a drift-correction step. The drift-correction step replaces the period once in every programmable number of cycles, so a slow or fast reference clock can be trimmed without changing the period. A new time is staged in three registers first. It takes effect only when the commit address is written, so seconds and nanoseconds always change together. Both timestamp outputs are continuous: they have no valid or ready signal and cannot be back-pressured, and every cycle presents a new value. The configuration port has no ready signal either, because every write completes in its cycle.

Top module: `tod_clock`

## Requirements
- R1: While `rst_n` is low, both `tod96` and `tod64` are zero. The period resets to 0x6_6666 (6.4 ns). The drift step and the drift gap reset to zero.
- R2: Each cycle without a commit adds the active step to {nanoseconds, fraction}. The 96-bit stamp is {seconds[47:0], nanoseconds[31:0], fraction[15:0]}, seconds in the most significant bits.
- R3: A write to address 0 sets the period from `cfg_wdata[19:0]`: bits 19:16 hold whole nanoseconds and bits 15:0 hold the fraction. The new period is used from the next cycle on. Without such a write the period holds.
- R4: A write to address 6 (commit) loads the staged seconds and nanoseconds into the counter at that clock edge, with the fraction cleared. The data bits of this write are ignored.
- R5: Writes to the staging registers have no effect on the outputs until a commit. The staging registers are address 3 (seconds bits 47:32, from `cfg_wdata[15:0]`), address 4 (seconds bits 31:0) and address 5 (nanoseconds).
- R6: When an addition brings the nanoseconds to 1,000,000,000 or more, 1,000,000,000 is subtracted and the seconds count increments by one in the same cycle.
- R7: A seconds increment carries from bit 31 into bits 47:32.
- R8: With a non-zero drift gap N (address 2, `cfg_wdata[31:0]`), every Nth increment after the gap write uses the drift step (address 1, same format as the period) in place of the period.
- R9: With a drift gap of zero, drift correction never takes effect.
- R10: When a commit falls in the cycle where the drift step is due, the load wins. The drift step is not added, and the cycle count still restarts.
- R11: `tod64` is {total nanoseconds[47:0], fraction[15:0]}. The total equals seconds × 10^9 + nanoseconds, modulo 2^48, and its fraction equals the fraction in `tod96`.
- R12: When the drift step is due in a cycle whose addition crosses the one-second boundary, the drift step is added and the wrap of R6 applies.
- R13: A write to address 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| tod96 | output | 96 | Seconds, nanoseconds and fraction stamp |
| tod64 | output | 64 | Total nanoseconds and fraction stamp |

## Verification
Two functions can land on the same edge in this block. A drift-due cycle can coincide with a time commit, and a drift-due cycle can coincide with a one-second rollover. The bench provokes the first by setting a drift gap of two and committing on exactly the second edge after the gap write. It then checks that the loaded time appears unchanged, and that the drift step arrives two cycles later. It provokes the second by committing a time one nanosecond below the boundary just before the drift step is due, and checks that the seconds advance and the nanoseconds land on the remainder.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int SEC_W      = 48;
  localparam int SEC_HI_W   = 16;
  localparam int NS_W       = 32;
  localparam int FRAC_W     = 16;
  localparam int STEP_INT_W = 4;
  localparam int STEP_W     = STEP_INT_W + FRAC_W;
  localparam int TOT_NS_W   = 48;
  localparam int TOT_W      = TOT_NS_W + FRAC_W;
  localparam int GAP_W      = 32;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 32;

  localparam logic [NS_W-1:0]   NS_PER_SEC = 32'd1_000_000_000;
  localparam logic [STEP_W-1:0] PERIOD_RST = 20'h6_6666;

  typedef enum logic [ADDR_W-1:0] {
    REG_PERIOD     = 3'd0,
    REG_DRIFT_STEP = 3'd1,
    REG_DRIFT_GAP  = 3'd2,
    REG_SEC_HI     = 3'd3,
    REG_SEC_LO     = 3'd4,
    REG_NSEC       = 3'd5,
    REG_COMMIT     = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } tod_load_t;
endpackage

// File: rtl/tod_cfg_regs.sv
module tod_cfg_regs
  import tod_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [STEP_W-1:0]     period_o,
  output logic [STEP_W-1:0]     drift_step_o,
  output logic [GAP_W-1:0]      drift_gap_o,
  output logic                  gap_wr_o,
  output logic                  commit_o,
  output tod_load_t             load_val_o
);
  logic [SEC_HI_W-1:0]       sec_hi_q;
  logic [SEC_W-SEC_HI_W-1:0] sec_lo_q;
  logic [NS_W-1:0]           ns_q;

  assign gap_wr_o   = wr_i && (addr_i == REG_DRIFT_GAP);
  assign commit_o   = wr_i && (addr_i == REG_COMMIT);
  assign load_val_o = '{sec: {sec_hi_q, sec_lo_q}, ns: ns_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_o     <= PERIOD_RST;
      drift_step_o <= '0;
      drift_gap_o  <= '0;
      sec_hi_q     <= '0;
      sec_lo_q     <= '0;
      ns_q         <= '0;
    end else if (wr_i) begin
      case (addr_i)
        REG_PERIOD:     period_o     <= wdata_i[STEP_W-1:0];
        REG_DRIFT_STEP: drift_step_o <= wdata_i[STEP_W-1:0];
        REG_DRIFT_GAP:  drift_gap_o  <= wdata_i[GAP_W-1:0];
        REG_SEC_HI:     sec_hi_q     <= wdata_i[SEC_HI_W-1:0];
        REG_SEC_LO:     sec_lo_q     <= wdata_i[SEC_W-SEC_HI_W-1:0];
        REG_NSEC:       ns_q         <= wdata_i[NS_W-1:0];
        default: ;
      endcase
    end
  end

  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && addr_i == REG_PERIOD) |=> $stable(period_o)); // R3
endmodule

// File: rtl/tod_drift_timer.sv
module tod_drift_timer
  import tod_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             clear_i,
  output logic             due_o
);
  logic [GAP_W-1:0] cnt_q;

  assign due_o = (gap_i != '0) && (cnt_q == gap_i - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clear_i || due_o) cnt_q <= '0;
    else if (gap_i != '0)      cnt_q <= cnt_q + 1'b1;
  end

  AST_DUE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (due_o && gap_i > 1 && !clear_i) |=> !due_o); // R8
endmodule

// File: rtl/tod_time_core.sv
module tod_time_core
  import tod_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STEP_W-1:0]   step_i,
  input  logic                load_i,
  input  tod_load_t           load_val_i,
  output logic [SEC_W-1:0]    sec_o,
  output logic [NS_W-1:0]     ns_o,
  output logic [FRAC_W-1:0]   frac_o,
  output logic [TOT_W-1:0]    tot_o
);
  localparam int NF_W = NS_W + FRAC_W;

  logic [NF_W:0]         nf_sum;
  logic [NS_W-1:0]       sum_ns;
  logic                  wrap;
  logic [TOT_NS_W-1:0]   load_total;

  assign nf_sum = {1'b0, ns_o, frac_o} + {{(NF_W+1-STEP_W){1'b0}}, step_i};
  assign sum_ns = nf_sum[NF_W-1:FRAC_W];
  assign wrap   = nf_sum[NF_W] || (sum_ns >= NS_PER_SEC);

  assign load_total = load_val_i.sec * {{(TOT_NS_W-NS_W){1'b0}}, NS_PER_SEC}
                    + {{(TOT_NS_W-NS_W){1'b0}}, load_val_i.ns};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_o  <= '0;
      ns_o   <= '0;
      frac_o <= '0;
      tot_o  <= '0;
    end else if (load_i) begin
      sec_o  <= load_val_i.sec;
      ns_o   <= load_val_i.ns;
      frac_o <= '0;
      tot_o  <= {load_total, {FRAC_W{1'b0}}};
    end else begin
      frac_o <= nf_sum[FRAC_W-1:0];
      ns_o   <= wrap ? (sum_ns - NS_PER_SEC) : sum_ns;
      sec_o  <= wrap ? (sec_o + 1'b1) : sec_o;
      tot_o  <= tot_o + {{(TOT_W-STEP_W){1'b0}}, step_i};
    end
  end

  AST_NS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && ns_o < NS_PER_SEC) |=> ns_o < NS_PER_SEC); // R6
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (sec_o == $past(sec_o) || sec_o == $past(sec_o) + 1'b1)); // R7
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (sec_o == $past(load_val_i.sec) && ns_o == $past(load_val_i.ns)
                && frac_o == '0)); // R4
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [DATA_W-1:0]          cfg_wdata,
  output logic [SEC_W+NS_W+FRAC_W-1:0] tod96,
  output logic [TOT_W-1:0]           tod64
);
  logic [STEP_W-1:0] period, drift_step, step;
  logic [GAP_W-1:0]  drift_gap;
  logic              gap_wr, commit, drift_due;
  tod_load_t         load_val;
  logic [SEC_W-1:0]  sec;
  logic [NS_W-1:0]   ns;
  logic [FRAC_W-1:0] frac;

  tod_cfg_regs u_cfg (
    .clk, .rst_n,
    .wr_i(cfg_wr), .addr_i(cfg_addr), .wdata_i(cfg_wdata),
    .period_o(period), .drift_step_o(drift_step), .drift_gap_o(drift_gap),
    .gap_wr_o(gap_wr), .commit_o(commit), .load_val_o(load_val)
  );

  tod_drift_timer u_timer (
    .clk, .rst_n, .gap_i(drift_gap), .clear_i(gap_wr), .due_o(drift_due)
  );

  assign step = drift_due ? drift_step : period;

  tod_time_core u_core (
    .clk, .rst_n, .step_i(step), .load_i(commit), .load_val_i(load_val),
    .sec_o(sec), .ns_o(ns), .frac_o(frac), .tot_o(tod64)
  );

  assign tod96 = {sec, ns, frac};

  AST_FRAC_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    tod64[FRAC_W-1:0] == tod96[FRAC_W-1:0]); // R11
endmodule

// File: tb/tod_clock_tb.sv
module tod_clock_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [95:0] tod96;
  logic [63:0] tod64;

  int checks = 0;
  int fails  = 0;

  // reference state
  logic [47:0] m_sec = '0;
  logic [31:0] m_ns = '0;
  logic [15:0] m_frac = '0;
  logic [63:0] m_tot = '0;
  logic [19:0] m_period = 20'h6_6666, m_dstep = '0;
  logic [31:0] m_gap = '0, m_cnt = '0;
  logic [15:0] m_shi = '0;
  logic [31:0] m_slo = '0, m_sns = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_clock u_dut (.clk, .rst_n, .cfg_wr, .cfg_addr, .cfg_wdata, .tod96, .tod64);

  task automatic model_step(input logic wr, input logic [2:0] a, input logic [31:0] d);
    logic        due;
    logic [19:0] st;
    logic [48:0] nf;
    logic [63:0] t;
    due = (m_gap != 0) && (m_cnt == m_gap - 1);
    st  = due ? m_dstep : m_period;
    if (wr && a == 3'd6) begin
      m_sec = {m_shi, m_slo}; m_ns = m_sns; m_frac = '0;
      t = {16'h0, m_sec} * 64'd1000000000 + {32'h0, m_ns};
      m_tot = {t[47:0], 16'h0};
    end else begin
      nf = {1'b0, m_ns, m_frac} + {29'h0, st};
      m_frac = nf[15:0];
      if (nf[48:16] >= 33'd1000000000) begin
        m_ns = nf[47:16] - 32'd1000000000; m_sec = m_sec + 1;
      end else m_ns = nf[47:16];
      m_tot = m_tot + {44'h0, st};
    end
    if (wr && a == 3'd2) m_cnt = 0;
    else if (due) m_cnt = 0;
    else if (m_gap != 0) m_cnt = m_cnt + 1;
    if (wr) case (a)
      3'd0: m_period = d[19:0];
      3'd1: m_dstep = d[19:0];
      3'd2: m_gap = d;
      3'd3: m_shi = d[15:0];
      3'd4: m_slo = d;
      3'd5: m_sns = d;
      default: ;
    endcase
  endtask

  task automatic check_model(input string req);
    checks++;
    if (tod96 !== {m_sec, m_ns, m_frac}) begin
      fails++; $display("FAIL %s tod96 actual=%h expected=%h", req, tod96, {m_sec, m_ns, m_frac});
    end
    checks++;
    if (tod64 !== m_tot) begin
      fails++; $display("FAIL %s tod64 actual=%h expected=%h", req, tod64, m_tot);
    end
  endtask

  task automatic expect96(input string req, input logic [47:0] s, input logic [31:0] n,
                          input logic [15:0] f);
    checks++;
    if (tod96 !== {s, n, f}) begin
      fails++; $display("FAIL %s tod96 actual=%h expected=%h", req, tod96, {s, n, f});
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string req);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    model_step(1'b1, a, d);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
    check_model(req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      model_step(1'b0, 3'd0, 32'd0);
      @(negedge clk);
      check_model(req);
    end
  endtask

  task automatic stage(input logic [47:0] s, input logic [31:0] n, input string req);
    wr(3'd3, {16'h0, s[47:32]}, req);
    wr(3'd4, s[31:0], req);
    wr(3'd5, n, req);
  endtask

  task automatic t_reset;
    expect96("R1", '0, '0, '0);
    checks++;
    if (tod64 !== '0) begin fails++; $display("FAIL R1 tod64 actual=%h expected=0", tod64); end
  endtask

  task automatic t_default_period;
    stage(48'd0, 32'd0, "R5");
    wr(3'd6, 32'hFFFF_FFFF, "R4");
    expect96("R4", '0, '0, '0);
    idle(5, "R2");
    expect96("R2", '0, 32'd31, 16'hFFFE); // 5 x 6.4 ns
  endtask

  task automatic t_load_staged;
    stage(48'h0001_2345_6789, 32'd500, "R5"); // outputs keep counting
    wr(3'd6, 32'd0, "R4");
    expect96("R4", 48'h0001_2345_6789, 32'd500, 16'h0);
    checks++;
    if (tod64 !== {48'h0001_2345_6789 * 48'd1000000000 + 48'd500, 16'h0}) begin
      fails++; $display("FAIL R11 tod64 actual=%h", tod64);
    end
  endtask

  task automatic t_period_and_wrap;
    wr(3'd0, 32'h0008_0000, "R3");
    stage(48'd7, 32'd999_999_990, "R6");
    wr(3'd6, 32'd0, "R6");
    idle(1, "R3");
    expect96("R3", 48'd7, 32'd999_999_998, 16'h0);
    idle(1, "R6");
    expect96("R6", 48'd8, 32'd6, 16'h0);
  endtask

  task automatic t_carry_high;
    stage(48'h0000_FFFF_FFFF, 32'd999_999_996, "R7");
    wr(3'd6, 32'd0, "R7");
    idle(1, "R7");
    expect96("R7", 48'h0001_0000_0000, 32'd4, 16'h0);
  endtask

  task automatic t_drift;
    wr(3'd1, 32'h0001_0000, "R8");
    stage(48'd3, 32'd0, "R8");
    wr(3'd2, 32'd3, "R8");
    wr(3'd6, 32'd0, "R8");
    expect96("R8", 48'd3, 32'd0, 16'h0);
    idle(1, "R8"); expect96("R8", 48'd3, 32'd8, 16'h0);
    idle(1, "R8"); expect96("R8", 48'd3, 32'd9, 16'h0);
    idle(1, "R8"); expect96("R8", 48'd3, 32'd17, 16'h0);
    idle(6, "R8");
  endtask

  task automatic t_gap_zero;
    wr(3'd2, 32'd0, "R9");
    stage(48'd4, 32'd0, "R9");
    wr(3'd6, 32'd0, "R9");
    idle(6, "R9");
    expect96("R9", 48'd4, 32'd48, 16'h0);
  endtask

  task automatic t_load_vs_drift;
    stage(48'd9, 32'd100, "R10");
    wr(3'd2, 32'd2, "R10");
    idle(1, "R10");
    wr(3'd6, 32'd0, "R10");           // drift due on this edge
    expect96("R10", 48'd9, 32'd100, 16'h0);
    idle(1, "R10"); expect96("R10", 48'd9, 32'd108, 16'h0);
    idle(1, "R10"); expect96("R10", 48'd9, 32'd109, 16'h0);
  endtask

  task automatic t_drift_wrap;
    wr(3'd1, 32'h0003_0000, "R12");
    stage(48'd1, 32'd999_999_999, "R12");
    wr(3'd2, 32'd2, "R12");
    wr(3'd6, 32'd0, "R12");
    idle(1, "R12");
    expect96("R12", 48'd2, 32'd2, 16'h0);
  endtask

  task automatic t_unused_addr;
    logic [31:0] n0;
    wr(3'd2, 32'd0, "R13");
    n0 = tod96[47:16];
    wr(3'd7, 32'h0000_0000, "R13");
    expect96("R13", tod96[95:48], n0 + 32'd8, 16'h0);
    idle(3, "R13");
    expect96("R13", tod96[95:48], n0 + 32'd32, 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(4, "R2");
    t_default_period();
    t_load_staged();
    t_period_and_wrap();
    t_carry_high();
    t_drift();
    t_gap_zero();
    t_load_vs_drift();
    t_drift_wrap();
    t_unused_addr();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule